// File: doc/BRIEF.md
# Stem Criticality Analysis Cell

This cell holds the criticality decision for one fanout stem while a single input vector is processed by a hardware critical-path tracer. Each fanout branch of the stem is sorted into one of two groups when the cell is instantiated.

A "safe" branch is one that never reconverges, or that reconverges only with the same inversion parity. A "cancelling" branch is one that reconverges with opposite parity. When any safe branch is critical, the stem is critical at once. No further work is needed.

When a cancelling branch is critical, the cell cannot decide by itself. It raises a request towards the group arbiter. When the arbiter inserts this stem's fault, the cell samples the error flags from the stem's observation points. The outcome is kept in two locking flags: one records that the analysis ran, and one records that the fault effect was observed. Both flags clear only on the per-vector restart. This means a stem is analysed at most once per vector, and a positive result stays visible until the next vector.

Top module: `stem_crit_cell`

## Requirements
- R1: After the global reset `rst` (synchronous, active high) both locking flags are clear. With no branch critical, `req` and `crit` are 0, and a critical cancelling branch raises `req` again.
- R2: In the same cycle that any bit of `safe_crit` is 1, `crit` is 1, whatever the state of the locking flags.
- R3: While the stem has not been analysed in this vector, `req` is 1 in the same cycle that any bit of `cancel_crit` is 1. It is 0 when all bits of `cancel_crit` are 0.
- R4: A clock edge with `insert` high marks the stem as analysed. From the next cycle on, `req` stays 0 even while `cancel_crit` is non-zero.
- R5: A clock edge with `insert` high and at least one `obs_err` bit high sets the detect flag. From the next cycle on, `crit` is 1 until the vector restart.
- R6: A clock edge with `insert` high and every `obs_err` bit low marks the stem as analysed but leaves it not detected. In that case `crit` follows only `safe_crit`.
- R7: `obs_err` has no effect on an edge where `insert` is low. Neither flag changes at that edge.
- R8: A clock edge with `vec_rst` high clears both flags. In the next cycle `crit` equals the OR of `safe_crit`, and `req` equals the OR of `cancel_crit`.
- R9: `vec_rst` wins over `insert` at the same edge. Both flags end up clear.
- R10: A fault effect seen at any single observation point is enough to set the detect flag. The lowest, middle and highest bits of `obs_err` each qualify on their own.
- R11: A critical cancelling branch alone never makes `crit` 1 before a detected analysis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| vec_rst | input | 1 | Synchronous restart at the start of each vector |
| safe_crit | input | N_SAFE | Criticality of branches that cannot cancel a fault effect |
| cancel_crit | input | N_CANCEL | Criticality of branches that reconverge with opposite parity |
| insert | input | 1 | Arbiter grant: this stem's fault is inserted in this cycle |
| obs_err | input | N_OBS | Comparator error flags at the stem's observation points |
| req | output | 1 | Analysis request towards the arbiter (combinational) |
| crit | output | 1 | Stem criticality for the current vector |

## Verification
A wrong "analysed" flag shows at the ports in the very next cycle after the faulty edge. Either `req` stays high after a grant, or `req` fails to come back after a vector restart. A wrong "detected" flag shows in `crit` on the cycle after the edge, once every safe branch is held low.

The bench therefore drives each reachable flag state through every combination of grant, observation flags and restart. Right after each edge it reads the new state back through `req` and `crit`. In every state it also sweeps all branch patterns against the combinational outputs.

// File: rtl/stem_crit_pkg.sv
package stem_crit_pkg;

    // Per-vector locking state of one stem.
    typedef struct packed {
        logic analysed;   // stem fault already inserted for this vector
        logic detected;   // fault effect seen at an observation point
    } stem_lock_t;

    localparam stem_lock_t LOCK_CLEAR = '{analysed: 1'b0, detected: 1'b0};

    // Next locking state: the restart wins, then the grant sets the flags.
    function automatic stem_lock_t lock_next(
        input stem_lock_t cur,
        input logic       restart,
        input logic       granted,
        input logic       seen
    );
        stem_lock_t nxt;
        nxt = cur;
        if (restart) begin
            nxt = LOCK_CLEAR;
        end else if (granted) begin
            nxt.analysed = 1'b1;
            if (seen) nxt.detected = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/branch_any.sv
module branch_any #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             any_out
);
    assign any_out = |bits_in;
endmodule

// File: rtl/stem_lock_reg.sv
module stem_lock_reg
    import stem_crit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       granted,
    input  logic       seen,
    output stem_lock_t lock_q
);
    stem_lock_t lock_d;

    always_comb lock_d = lock_next(lock_q, restart, granted, seen);

    always_ff @(posedge clk) begin
        if (rst) lock_q <= LOCK_CLEAR;
        else     lock_q <= lock_d;
    end
endmodule

// File: rtl/stem_crit_cell.sv
module stem_crit_cell
    import stem_crit_pkg::*;
#(
    parameter int N_SAFE   = 3,
    parameter int N_CANCEL = 2,
    parameter int N_OBS    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vec_rst,
    input  logic [N_SAFE-1:0]   safe_crit,
    input  logic [N_CANCEL-1:0] cancel_crit,
    input  logic                insert,
    input  logic [N_OBS-1:0]    obs_err,
    output logic                req,
    output logic                crit
);
    logic       direct_hit;
    logic       cancel_hit;
    logic       fault_seen;
    stem_lock_t lock;

    branch_any #(.WIDTH(N_SAFE))   u_safe   (.bits_in(safe_crit),   .any_out(direct_hit));
    branch_any #(.WIDTH(N_CANCEL)) u_cancel (.bits_in(cancel_crit), .any_out(cancel_hit));
    branch_any #(.WIDTH(N_OBS))    u_obs    (.bits_in(obs_err),     .any_out(fault_seen));

    stem_lock_reg u_lock (
        .clk    (clk),
        .rst    (rst),
        .restart(vec_rst),
        .granted(insert),
        .seen   (fault_seen),
        .lock_q (lock)
    );

    // The request is combinational, so the arbiter sees it in the same cycle.
    assign req  = cancel_hit & ~lock.analysed;
    assign crit = direct_hit | lock.detected;
endmodule

// File: rtl/stem_crit_cell_chk.sv
module stem_crit_cell_chk #(
    parameter int N_SAFE   = 3,
    parameter int N_CANCEL = 2,
    parameter int N_OBS    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                vec_rst,
    input logic [N_SAFE-1:0]   safe_crit,
    input logic [N_CANCEL-1:0] cancel_crit,
    input logic                insert,
    input logic [N_OBS-1:0]    obs_err,
    input logic                req,
    input logic                crit
);
    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (req == (|cancel_crit)));

    assert_safe_direct_R2: assert property (@(posedge clk) disable iff (rst)
        (|safe_crit) |-> crit);

    assert_grant_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (insert && !vec_rst) |=> !req);

    assert_blocked_holds_R4: assert property (@(posedge clk) disable iff (rst)
        ((|cancel_crit) && !req && !vec_rst) |=> !req);

    assert_detect_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (insert && (|obs_err) && !vec_rst) |=> crit);

    assert_idle_keeps_req_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !insert && !vec_rst) |=> (req == (|cancel_crit)));

    assert_restart_crit_R8: assert property (@(posedge clk) disable iff (rst)
        vec_rst |=> (crit == (|safe_crit)));

    assert_restart_req_R9: assert property (@(posedge clk) disable iff (rst)
        vec_rst |=> (req == (|cancel_crit)));
endmodule

bind stem_crit_cell stem_crit_cell_chk #(
    .N_SAFE(N_SAFE), .N_CANCEL(N_CANCEL), .N_OBS(N_OBS)
) u_chk (
    .clk(clk), .rst(rst), .vec_rst(vec_rst), .safe_crit(safe_crit),
    .cancel_crit(cancel_crit), .insert(insert), .obs_err(obs_err),
    .req(req), .crit(crit)
);

// File: tb/stem_crit_cell_bench.sv
module stem_crit_cell_bench;
    localparam int NS = 3, NC = 2, NO = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vec_rst = 1'b0;
    logic [NS-1:0] safe_crit = '0;
    logic [NC-1:0] cancel_crit = '0;
    logic          insert = 1'b0;
    logic [NO-1:0] obs_err = '0;
    logic          req, crit;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    stem_crit_cell #(.N_SAFE(NS), .N_CANCEL(NC), .N_OBS(NO)) u_stem_crit_cell (
        .clk(clk), .rst(rst), .vec_rst(vec_rst), .safe_crit(safe_crit),
        .cancel_crit(cancel_crit), .insert(insert), .obs_err(obs_err),
        .req(req), .crit(crit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock edge with the given controls; returns 1 ns after the edge.
    task automatic edge_with(input logic vr, input logic ins, input logic [NO-1:0] ob);
        vec_rst = vr; insert = ins; obs_err = ob;
        @(posedge clk); #1;
        vec_rst = 0; insert = 0; obs_err = '0;
    endtask

    // Read the two flags through the ports: req shows "analysed", crit shows "detected".
    task automatic probe(input string tag, input logic exp_an, input logic exp_det);
        safe_crit = '0; cancel_crit = 2'b01; #1;
        check({tag, " req"},  req,  ~exp_an);
        check({tag, " crit"}, crit, exp_det);
        cancel_crit = '0;
    endtask

    task automatic reach(input int st);
        edge_with(1, 0, '0);
        if (st == 1) edge_with(0, 1, '0);
        if (st == 2) edge_with(0, 1, 3'b010);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1 rst = 0; #1;
        check("R1 req idle", req, 1'b0);
        check("R1 crit idle", crit, 1'b0);
        probe("R1 after reset", 0, 0);

        // Combinational sweep in each reachable state (R2, R3, R4, R11)
        for (int st = 0; st < 3; st++) begin
            logic an, dt;
            an = (st != 0); dt = (st == 2);
            reach(st);
            for (int s = 0; s < (1 << NS); s++) begin
                for (int c = 0; c < (1 << NC); c++) begin
                    safe_crit = s[NS-1:0]; cancel_crit = c[NC-1:0]; #1;
                    check(an ? "R4 req gated" : "R3 req raised", req, (c != 0) && !an);
                    check((s != 0) ? "R2 crit direct" : "R11 crit no direct", crit, (s != 0) || dt);
                end
            end
            safe_crit = '0; cancel_crit = '0;
        end

        // Edge sweep: every state x restart x grant x observation pattern (R4-R10)
        for (int st = 0; st < 3; st++) begin
            for (int vr = 0; vr < 2; vr++) begin
                for (int ins = 0; ins < 2; ins++) begin
                    for (int ob = 0; ob < (1 << NO); ob++) begin
                        logic an, dt;
                        string tg;
                        an = (st != 0); dt = (st == 2);
                        if (vr != 0) begin
                            an = 0; dt = 0;
                            tg = (ins != 0) ? "R9 restart wins" : "R8 restart";
                        end else if (ins != 0) begin
                            an = 1;
                            if (ob != 0) dt = 1;
                            tg = (ob != 0) ? ((ob == 1 || ob == 2 || ob == 4) ? "R10 single point" : "R5 detect")
                                           : "R6 no detect";
                        end else begin
                            tg = "R7 no grant";
                        end
                        reach(st);
                        edge_with(vr[0], ins[0], ob[NO-1:0]);
                        probe(tg, an, dt);
                    end
                end
            end
        end

        // R5: detection held over idle cycles
        reach(2);
        repeat (3) edge_with(0, 0, 3'b111);
        probe("R5 held", 1, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule